// File: doc/BRIEF.md
# Load-Load Ordering Violation Queue

This block keeps a small table of loads that have already produced their data, so that a later-issuing but older load can find out whether a younger load to the same cache line read a value that has since gone stale. Each load in pipeline stage 2 presents its age and its physical line address. The block checks that load against the table and also takes a free slot to record it. The verdict comes out one cycle later, in stage 3. When the verdict is a violation, the block drives a redirect toward the redirect-generation logic. The redirect carries the querying load's age, and every instruction younger than that load is to be flushed.

Invalidation of a line, which stands for snoop and release traffic from the cache, is reduced to a single line-invalidate input. It marks the matching recorded loads as having lost their line. Slots are freed when a commit age passes them or when a pipeline flush covers them. When the table is full, a stage-2 query is turned back for replay and leaves no trace.

Top module: `ldld_order_queue`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the table is empty, `s3_valid`, `s3_violation`, `redir_valid` and `s2_replay` are 0.
- R2: A stage-2 query (`s2_valid`=1) made while fewer than DEPTH slots are occupied is accepted: `s2_replay` stays 0 and the load is recorded with its age and line, not yet marked invalidated.
- R3: A stage-2 query made while all DEPTH slots are occupied drives `s2_replay`=1 in that same cycle, records nothing and produces no stage-3 result.
- R4: `s3_valid` is 1 in exactly the cycle after an accepted stage-2 query, and 0 otherwise.
- R5: `s3_violation` is 1 with `s3_valid` exactly when, in the query cycle, some recorded load had the same line, had been marked invalidated, and was younger than the querying load.
- R6: `inv_valid` marks every slot recorded before that cycle whose line equals `inv_line`. A load recorded in the same cycle as the invalidate is not marked.
- R7: Ages are an index plus a wrap bit. Age A is younger than age B when the wrap bits are equal and A's index is larger, or when the wrap bits differ and A's index is smaller.
- R8: `redir_valid` equals `s3_valid` AND `s3_violation`, and `redir_idx`/`redir_wrap` then hold the querying load's age.
- R9: A flush whose age is not younger than a slot's age frees that slot at the clock edge. A stage-2 query in the same cycle whose age is not older than the flush age is neither recorded nor reported in stage 3.
- R10: A commit frees at the clock edge every slot whose age is not younger than the commit age.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s2_valid | input | 1 | Stage-2 load query present |
| s2_idx | input | IDX_W | Query age index |
| s2_wrap | input | 1 | Query age wrap bit |
| s2_line | input | LINE_W | Query physical line address |
| s2_replay | output | 1 | Query not accepted, table full |
| inv_valid | input | 1 | Line invalidate strobe |
| inv_line | input | LINE_W | Invalidated line address |
| commit_valid | input | 1 | Commit release strobe |
| commit_idx | input | IDX_W | Commit age index |
| commit_wrap | input | 1 | Commit age wrap bit |
| flush_valid | input | 1 | Pipeline flush strobe |
| flush_idx | input | IDX_W | Flush age index |
| flush_wrap | input | 1 | Flush age wrap bit |
| s3_valid | output | 1 | Stage-3 verdict present |
| s3_violation | output | 1 | Stage-3 verdict is a violation |
| redir_valid | output | 1 | Redirect request |
| redir_idx | output | IDX_W | Redirect age index (flush younger) |
| redir_wrap | output | 1 | Redirect age wrap bit |

## Verification
The assertions assume that at most one query arrives per cycle and that inputs are driven to known values from reset onward. Beyond that, they rely on nothing about the ages, lines or the order of strobes. The stimulus changes inputs only at the falling clock edge and keeps line addresses in a range of four values, so that line matches, invalidates and violations happen often. Random ages may wrap either way. The reference applies the same ordering rule given in R7, so arbitrary age pairs stay legal. Directed sequences cover full-table replay, a flush that meets a query in the same cycle, partial commits, an invalidate that coincides with an allocation, and a violation across the wrap boundary.

// File: rtl/ldq_pkg.sv
package ldq_pkg;

   // Per-slot action chosen each cycle
   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_FILL = 2'd1,
      OP_MARK = 2'd2,
      OP_DROP = 2'd3
   } slot_op_e;

   localparam int MIN_DEPTH = 2;
   localparam int MIN_IDX_W = 2;

endpackage

// File: rtl/ldq_age_cmp.sv
// a_younger is 1 when age A is strictly younger than age B.
module ldq_age_cmp #(
   parameter int IDX_W = 6
) (
   input  logic [IDX_W-1:0] a_idx,
   input  logic             a_wrap,
   input  logic [IDX_W-1:0] b_idx,
   input  logic             b_wrap,
   output logic             a_younger
);

   always_comb begin
      if (a_wrap == b_wrap) a_younger = (a_idx > b_idx);
      else                  a_younger = (a_idx < b_idx);
   end

endmodule

// File: rtl/ldq_entry.sv
module ldq_entry
   import ldq_pkg::*;
#(
   parameter int IDX_W  = 6,
   parameter int LINE_W = 26
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill_en,
   input  logic [IDX_W-1:0]  fill_idx,
   input  logic              fill_wrap,
   input  logic [LINE_W-1:0] fill_line,
   input  logic              inv_valid,
   input  logic [LINE_W-1:0] inv_line,
   input  logic              commit_valid,
   input  logic [IDX_W-1:0]  commit_idx,
   input  logic              commit_wrap,
   input  logic              flush_valid,
   input  logic [IDX_W-1:0]  flush_idx,
   input  logic              flush_wrap,
   input  logic [IDX_W-1:0]  q_idx,
   input  logic              q_wrap,
   input  logic [LINE_W-1:0] q_line,
   output logic              busy,
   output logic              hit
);

   logic [IDX_W-1:0]  age_idx;
   logic              age_wrap;
   logic [LINE_W-1:0] line;
   logic              released;

   logic ent_younger_q;
   logic flush_younger_ent;
   logic ent_younger_commit;
   slot_op_e op;

   ldq_age_cmp #(.IDX_W(IDX_W)) u_vs_query (
      .a_idx(age_idx), .a_wrap(age_wrap),
      .b_idx(q_idx),   .b_wrap(q_wrap),
      .a_younger(ent_younger_q)
   );

   ldq_age_cmp #(.IDX_W(IDX_W)) u_vs_flush (
      .a_idx(flush_idx), .a_wrap(flush_wrap),
      .b_idx(age_idx),   .b_wrap(age_wrap),
      .a_younger(flush_younger_ent)
   );

   ldq_age_cmp #(.IDX_W(IDX_W)) u_vs_commit (
      .a_idx(age_idx),    .a_wrap(age_wrap),
      .b_idx(commit_idx), .b_wrap(commit_wrap),
      .a_younger(ent_younger_commit)
   );

   // Flush beats commit beats invalidate; an empty slot may only fill
   always_comb begin
      op = OP_HOLD;
      if (busy) begin
         if (flush_valid && !flush_younger_ent)        op = OP_DROP;
         else if (commit_valid && !ent_younger_commit) op = OP_DROP;
         else if (inv_valid && (inv_line == line))     op = OP_MARK;
      end else if (fill_en) begin
         op = OP_FILL;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         released <= 1'b0;
         age_idx  <= '0;
         age_wrap <= 1'b0;
         line     <= '0;
      end else begin
         case (op)
            OP_DROP: begin
               busy     <= 1'b0;
               released <= 1'b0;
            end
            OP_MARK: released <= 1'b1;
            OP_FILL: begin
               busy     <= 1'b1;
               released <= 1'b0;
               age_idx  <= fill_idx;
               age_wrap <= fill_wrap;
               line     <= fill_line;
            end
            default: ;
         endcase
      end
   end

   assign hit = busy && released && (line == q_line) && ent_younger_q;

endmodule

// File: rtl/ldq_free_pick.sv
// Grants the lowest-numbered empty slot.
module ldq_free_pick #(
   parameter int DEPTH = 8
) (
   input  logic [DEPTH-1:0] busy,
   output logic [DEPTH-1:0] grant,
   output logic             any_free
);

   always_comb begin
      logic found;
      found = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         grant[i] = !busy[i] && !found;
         found    = found | !busy[i];
      end
      any_free = found;
   end

endmodule

// File: rtl/ldq_s3_stage.sv
module ldq_s3_stage #(
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             viol_in,
   input  logic [IDX_W-1:0] age_idx_in,
   input  logic             age_wrap_in,
   output logic             s3_valid,
   output logic             s3_violation,
   output logic             redir_valid,
   output logic [IDX_W-1:0] redir_idx,
   output logic             redir_wrap
);

   logic viol_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s3_valid   <= 1'b0;
         viol_q     <= 1'b0;
         redir_idx  <= '0;
         redir_wrap <= 1'b0;
      end else begin
         s3_valid <= take;
         if (take) begin
            viol_q     <= viol_in;
            redir_idx  <= age_idx_in;
            redir_wrap <= age_wrap_in;
         end
      end
   end

   assign s3_violation = s3_valid && viol_q;
   assign redir_valid  = s3_valid && viol_q;

endmodule

// File: rtl/ldld_order_queue.sv
module ldld_order_queue
   import ldq_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int IDX_W  = 6,
   parameter int LINE_W = 26
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s2_valid,
   input  logic [IDX_W-1:0]  s2_idx,
   input  logic              s2_wrap,
   input  logic [LINE_W-1:0] s2_line,
   output logic              s2_replay,
   input  logic              inv_valid,
   input  logic [LINE_W-1:0] inv_line,
   input  logic              commit_valid,
   input  logic [IDX_W-1:0]  commit_idx,
   input  logic              commit_wrap,
   input  logic              flush_valid,
   input  logic [IDX_W-1:0]  flush_idx,
   input  logic              flush_wrap,
   output logic              s3_valid,
   output logic              s3_violation,
   output logic              redir_valid,
   output logic [IDX_W-1:0]  redir_idx,
   output logic              redir_wrap
);

   // Elaboration-time parameter checks
   if (DEPTH < MIN_DEPTH) begin : g_bad_depth
      $error("ldld_order_queue: DEPTH below minimum");
   end
   if (IDX_W < MIN_IDX_W) begin : g_bad_idx
      $error("ldld_order_queue: IDX_W below minimum");
   end
   if (LINE_W < 1) begin : g_bad_line
      $error("ldld_order_queue: LINE_W must be positive");
   end

   logic [DEPTH-1:0] ent_busy;
   logic [DEPTH-1:0] ent_hit;
   logic [DEPTH-1:0] grant;
   logic [DEPTH-1:0] fill_en;
   logic             any_free;
   logic             flush_younger_s2;
   logic             s2_killed;
   logic             s2_accept;

   ldq_age_cmp #(.IDX_W(IDX_W)) u_s2_vs_flush (
      .a_idx(flush_idx), .a_wrap(flush_wrap),
      .b_idx(s2_idx),    .b_wrap(s2_wrap),
      .a_younger(flush_younger_s2)
   );

   ldq_free_pick #(.DEPTH(DEPTH)) u_pick (
      .busy(ent_busy),
      .grant(grant),
      .any_free(any_free)
   );

   assign s2_killed = flush_valid && !flush_younger_s2;
   assign s2_accept = s2_valid && any_free && !s2_killed;
   assign s2_replay = s2_valid && !any_free;
   assign fill_en   = grant & {DEPTH{s2_accept}};

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      ldq_entry #(.IDX_W(IDX_W), .LINE_W(LINE_W)) u_entry (
         .clk(clk),
         .rst_n(rst_n),
         .fill_en(fill_en[g]),
         .fill_idx(s2_idx),
         .fill_wrap(s2_wrap),
         .fill_line(s2_line),
         .inv_valid(inv_valid),
         .inv_line(inv_line),
         .commit_valid(commit_valid),
         .commit_idx(commit_idx),
         .commit_wrap(commit_wrap),
         .flush_valid(flush_valid),
         .flush_idx(flush_idx),
         .flush_wrap(flush_wrap),
         .q_idx(s2_idx),
         .q_wrap(s2_wrap),
         .q_line(s2_line),
         .busy(ent_busy[g]),
         .hit(ent_hit[g])
      );
   end

   ldq_s3_stage #(.IDX_W(IDX_W)) u_s3 (
      .clk(clk),
      .rst_n(rst_n),
      .take(s2_accept),
      .viol_in(|ent_hit),
      .age_idx_in(s2_idx),
      .age_wrap_in(s2_wrap),
      .s3_valid(s3_valid),
      .s3_violation(s3_violation),
      .redir_valid(redir_valid),
      .redir_idx(redir_idx),
      .redir_wrap(redir_wrap)
   );

endmodule

// File: rtl/ldq_checks.sv
module ldq_checks #(
   parameter int DEPTH = 8,
   parameter int IDX_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             s2_valid,
   input logic [IDX_W-1:0] s2_idx,
   input logic             s2_wrap,
   input logic             s2_replay,
   input logic [DEPTH-1:0] ent_busy,
   input logic [DEPTH-1:0] fill_en,
   input logic             s3_valid,
   input logic             redir_valid,
   input logic [IDX_W-1:0] redir_idx,
   input logic             redir_wrap
);

   p_replay_only_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      s2_replay |-> ($countones(ent_busy) == DEPTH));

   p_replay_needs_query_r3: assert property (@(posedge clk) disable iff (!rst_n)
      s2_replay |-> s2_valid);

   p_single_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fill_en));

   p_fill_not_replayed_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|fill_en) |-> (s2_valid && !s2_replay));

   p_s3_after_s2_r4: assert property (@(posedge clk) disable iff (!rst_n)
      s3_valid |-> $past(s2_valid && !s2_replay));

   p_redir_age_r8: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |-> (redir_idx == $past(s2_idx) && redir_wrap == $past(s2_wrap)));

endmodule

bind ldld_order_queue ldq_checks #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_checks (
   .clk(clk),
   .rst_n(rst_n),
   .s2_valid(s2_valid),
   .s2_idx(s2_idx),
   .s2_wrap(s2_wrap),
   .s2_replay(s2_replay),
   .ent_busy(ent_busy),
   .fill_en(fill_en),
   .s3_valid(s3_valid),
   .redir_valid(redir_valid),
   .redir_idx(redir_idx),
   .redir_wrap(redir_wrap)
);

// File: tb/tb_ldld_order_queue.sv
`timescale 1ns/1ps
module tb_ldld_order_queue;

   localparam int DEPTH  = 8;
   localparam int IDX_W  = 6;
   localparam int LINE_W = 26;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic s2_valid = 1'b0, s2_wrap = 1'b0;
   logic [IDX_W-1:0] s2_idx = '0;
   logic [LINE_W-1:0] s2_line = '0;
   logic s2_replay;
   logic inv_valid = 1'b0;
   logic [LINE_W-1:0] inv_line = '0;
   logic commit_valid = 1'b0, commit_wrap = 1'b0;
   logic [IDX_W-1:0] commit_idx = '0;
   logic flush_valid = 1'b0, flush_wrap = 1'b0;
   logic [IDX_W-1:0] flush_idx = '0;
   logic s3_valid, s3_violation, redir_valid, redir_wrap;
   logic [IDX_W-1:0] redir_idx;

   always #10 clk = ~clk;

   ldld_order_queue #(.DEPTH(DEPTH), .IDX_W(IDX_W), .LINE_W(LINE_W)) dut (
      .clk(clk), .rst_n(rst_n),
      .s2_valid(s2_valid), .s2_idx(s2_idx), .s2_wrap(s2_wrap), .s2_line(s2_line),
      .s2_replay(s2_replay),
      .inv_valid(inv_valid), .inv_line(inv_line),
      .commit_valid(commit_valid), .commit_idx(commit_idx), .commit_wrap(commit_wrap),
      .flush_valid(flush_valid), .flush_idx(flush_idx), .flush_wrap(flush_wrap),
      .s3_valid(s3_valid), .s3_violation(s3_violation),
      .redir_valid(redir_valid), .redir_idx(redir_idx), .redir_wrap(redir_wrap)
   );

   typedef struct { int idx; bit w; int line; bit rel; } rec_t;
   rec_t model[$];

   int checks = 0;
   int errors = 0;
   string scen = "R2";

   // Expected registered outputs
   bit exp_v = 0, exp_viol = 0, exp_w = 0;
   int exp_idx = 0;

   // Staged stimulus for the next cycle
   bit st_sv, st_sw, st_iv, st_cv, st_cw, st_fv, st_fw;
   int st_si, st_sl, st_il, st_ci, st_fi;

   function automatic bit yng(int ai, bit aw, int bi, bit bw);
      if (aw == bw) return ai > bi;
      return ai < bi;
   endfunction

   task automatic chk(bit ok, string tag, string what, int got, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s (%s) %s: got %0d expected %0d", tag, scen, what, got, exp);
      end
   endtask

   task automatic clear_stage();
      st_sv = 0; st_sw = 0; st_iv = 0; st_cv = 0; st_cw = 0; st_fv = 0; st_fw = 0;
      st_si = 0; st_sl = 0; st_il = 0; st_ci = 0; st_fi = 0;
   endtask

   task automatic q(int idx, bit w, int line);
      st_sv = 1; st_si = idx; st_sw = w; st_sl = line;
   endtask

   task automatic cycle();
      bit full, kill, acc, viol, exp_rep, drop;
      rec_t nq[$];
      rec_t e;
      @(negedge clk);
      chk(s3_valid === exp_v, "R4", "s3_valid", int'(s3_valid), int'(exp_v));
      chk(s3_violation === (exp_v & exp_viol), "R5", "s3_violation",
          int'(s3_violation), int'(exp_v & exp_viol));
      chk(redir_valid === (exp_v & exp_viol), "R8", "redir_valid",
          int'(redir_valid), int'(exp_v & exp_viol));
      if (exp_v && exp_viol)
         chk(redir_idx == exp_idx[IDX_W-1:0] && redir_wrap == exp_w, "R8", "redir age",
             int'({redir_wrap, redir_idx}), int'({exp_w, exp_idx[IDX_W-1:0]}));
      s2_valid = st_sv; s2_idx = st_si[IDX_W-1:0]; s2_wrap = st_sw; s2_line = st_sl[LINE_W-1:0];
      inv_valid = st_iv; inv_line = st_il[LINE_W-1:0];
      commit_valid = st_cv; commit_idx = st_ci[IDX_W-1:0]; commit_wrap = st_cw;
      flush_valid = st_fv; flush_idx = st_fi[IDX_W-1:0]; flush_wrap = st_fw;
      #1;
      full = (model.size() >= DEPTH);
      kill = st_fv && !yng(st_fi, st_fw, st_si, st_sw);
      acc = st_sv && !full && !kill;
      exp_rep = st_sv && full;
      chk(s2_replay === exp_rep, "R3", "s2_replay", int'(s2_replay), int'(exp_rep));
      viol = 0;
      foreach (model[k])
         if (model[k].rel && model[k].line == st_sl && yng(model[k].idx, model[k].w, st_si, st_sw))
            viol = 1;
      foreach (model[k]) begin
         e = model[k];
         drop = (st_fv && !yng(st_fi, st_fw, e.idx, e.w)) ||
                (st_cv && !yng(e.idx, e.w, st_ci, st_cw));
         if (!drop) begin
            if (st_iv && e.line == st_il) e.rel = 1;
            nq.push_back(e);
         end
      end
      if (acc) nq.push_back('{st_si, st_sw, st_sl, 1'b0});
      model = nq;
      exp_v = acc; exp_viol = viol; exp_idx = st_si; exp_w = st_sw;
      clear_stage();
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      clear_stage();
      s2_valid = 0; inv_valid = 0; commit_valid = 0; flush_valid = 0;
      model.delete();
      exp_v = 0; exp_viol = 0;
      repeat (2) @(negedge clk);
      chk(s3_valid === 1'b0, "R1", "s3_valid in reset", int'(s3_valid), 0);
      chk(redir_valid === 1'b0, "R1", "redir_valid in reset", int'(redir_valid), 0);
      chk(s3_violation === 1'b0, "R1", "s3_violation in reset", int'(s3_violation), 0);
      chk(s2_replay === 1'b0, "R1", "s2_replay in reset", int'(s2_replay), 0);
      rst_n = 1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R4 watchdog expired: got 0 expected 1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      clear_stage();
      do_reset();

      // R2 fill, R3 full replay, R10 partial commit
      scen = "R2";
      for (int i = 10; i < 18; i++) begin q(i, 0, 1); cycle(); end
      scen = "R3";
      q(18, 0, 1); cycle();
      q(19, 0, 1); cycle();
      scen = "R10";
      st_cv = 1; st_ci = 13; st_cw = 0; cycle();
      for (int i = 20; i < 25; i++) begin q(i, 0, 1); cycle(); end
      cycle();

      // R5 violation, R6 invalidate coinciding with allocation
      do_reset();
      scen = "R5";
      q(20, 0, 2); cycle();
      scen = "R6";
      q(21, 0, 2); st_iv = 1; st_il = 2; cycle();
      scen = "R5";
      q(15, 0, 2); cycle();
      scen = "R6";
      st_cv = 1; st_ci = 20; st_cw = 0; cycle();
      q(16, 0, 2); cycle();
      cycle();

      // R7 ordering across the wrap boundary
      do_reset();
      scen = "R7";
      q(2, 1, 3); cycle();
      st_iv = 1; st_il = 3; cycle();
      q(60, 0, 3); cycle();
      q(5, 1, 3); cycle();
      cycle();

      // R9 flush with a same-cycle query
      do_reset();
      scen = "R9";
      for (int i = 30; i < 38; i++) begin q(i, 0, 0); cycle(); end
      q(40, 0, 0); st_fv = 1; st_fi = 34; st_fw = 0; cycle();
      for (int i = 41; i < 46; i++) begin q(i, 0, 0); cycle(); end
      q(20, 0, 0); st_fv = 1; st_fi = 25; st_fw = 0; cycle();
      cycle();

      // Mixed traffic
      do_reset();
      scen = "R5";
      for (int n = 0; n < 4000; n++) begin
         if ($urandom_range(0, 9) < 7)
            q(int'($urandom_range(0, 63)), 1'($urandom_range(0, 1)), int'($urandom_range(0, 3)));
         if ($urandom_range(0, 3) == 0) begin st_iv = 1; st_il = int'($urandom_range(0, 3)); end
         if ($urandom_range(0, 9) == 0) begin
            st_cv = 1; st_ci = int'($urandom_range(0, 63)); st_cw = 1'($urandom_range(0, 1));
         end
         if ($urandom_range(0, 19) == 0) begin
            st_fv = 1; st_fi = int'($urandom_range(0, 63)); st_fw = 1'($urandom_range(0, 1));
         end
         cycle();
      end
      cycle();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule